// File: doc/BRIEF.md
# Clock Generator Configuration Port (I2C Block-Transfer Slave)

This block is the serial configuration port of a clock generator. It answers on a two-wire I2C bus and holds six 8-bit control bytes that set frequency selection, spread mode and per-output enables. The six bytes drive the rest of the chip in parallel on `cfg_o`. A host changes them with one block write. That write is an address byte, a command byte and a count byte, followed by data bytes. The data bytes always land in byte 0, then byte 1, and so on, because there is no register pointer. A block read returns a count byte and then the six bytes in order.

The bus lines reach the block as levels sampled by a fast system clock. `sda_oe` pulls SDA low when it is high, so the pad works as an open-drain output. Some bit positions report values latched from pins elsewhere on the chip. These positions are read-only. Their value comes from `status_in`, both on `cfg_o` and in readback, and a write to them has no effect.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset, byte 0 holds 0x00 and every writable bit of bytes 1 to 5 holds 1. Byte k appears on `cfg_o[8k+7:8k]`, and SDA is released.
- R2: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read). Any other address is not acknowledged, and the registers do not change.
- R3: In a write, the slave acknowledges the two bytes that follow the address and discards their values. It then stores each acknowledged data byte in the next register, starting at byte 0 and going upward.
- R4: A STOP after any complete data byte ends the write. Bytes already written keep their new values, and the other bytes are unchanged.
- R5: A seventh data byte, and any byte after it, is not acknowledged and is not stored.
- R6: A read sends the count value 6 first and then bytes 0 to 5. Each byte is sent most significant bit first, and the master acknowledges each one.
- R7: When the master does not acknowledge a read byte, the slave stops sending and keeps SDA released until the next START.
- R8: Read-only positions are byte 1 bit 7, byte 3 bit 6, byte 4 bit 3 and byte 4 bit 1. On `cfg_o` and in readback they always show the matching bits of `status_in`, and writes to them are ignored.
- R9: A repeated START, even in the middle of a byte, abandons the current transfer and starts address matching again. The data sequence of the new transfer starts again at byte 0.
- R10: SDA drive changes only just after a synchronized SCL falling edge or a START/STOP, and a STOP always releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL level from the pad |
| sda_in | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | Pull SDA low when high |
| status_in | input | 48 | Live latched values for the read-only positions, laid out as `cfg_o` |
| cfg_o | output | 48 | Registered control bytes, byte k at bits 8k+7:8k |

## Verification
The bench aims at the places where the byte sequencing can go wrong. One is a write cut short by STOP. A design that fails here would corrupt or reset the bytes that were never sent. Another is a write that runs past byte 5. A design that fails here would acknowledge the extra byte or wrap it into byte 0. A third is a repeated START in the middle of a byte. A design that keeps its byte counter across that START would put the next data in the wrong register, or would not re-match the address. The bench also changes the read-only status between transfers and tries to write over it. It checks that the early NACK of a read releases the bus, because a design that kept driving would hold SDA low while the master is trying to stop.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_RD_LOAD
  } xfer_state_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_h,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sr;
  logic [STAGES-1:0] sda_sr;
  logic              scl_q;
  logic              sda_q;
  logic              scl_h;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= scl_in;
          sda_sr <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= {scl_sr[STAGES-2:0], scl_in};
          sda_sr <= {sda_sr[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_h = scl_sr[STAGES-1];
  assign sda_h = sda_sr[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_h;
      sda_q <= sda_h;
    end
  end

  assign scl_rise  = scl_h & ~scl_q;
  assign scl_fall  = ~scl_h & scl_q;
  assign start_det = scl_h & scl_q & sda_q & ~sda_h;
  assign stop_det  = scl_h & scl_q & ~sda_q & sda_h;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int                      NUM_REGS  = 6,
  parameter logic [NUM_REGS*8-1:0]   RESET_VAL = '1,
  parameter logic [NUM_REGS*8-1:0]   RO_MASK   = '0,
  localparam int                     IDX_W     = $clog2(NUM_REGS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_data,
  input  logic [NUM_REGS*8-1:0]   status_in,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [7:0]              rd_data,
  output logic [NUM_REGS*8-1:0]   cfg_o
);

  logic [7:0] store  [NUM_REGS];
  logic [7:0] merged [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    localparam logic [7:0] RV = RESET_VAL[g*8 +: 8];
    localparam logic [7:0] RM = RO_MASK[g*8 +: 8];

    always_ff @(posedge clk) begin
      if (rst) begin
        store[g] <= RV;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        store[g] <= wr_data;
      end
    end

    assign merged[g] = (store[g] & ~RM) | (status_in[g*8 +: 8] & RM);

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_o[g*8 +: 8] <= (RV & ~RM) | (status_in[g*8 +: 8] & RM);
      end else begin
        cfg_o[g*8 +: 8] <= merged[g];
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = merged[i];
    end
  end

endmodule

// File: rtl/cfg_proto_fsm.sv
module cfg_proto_fsm
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         NUM_REGS   = 6,
  parameter int         HDR_BYTES  = 2,
  localparam int        IDX_W      = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_h,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);

  localparam int RX_MAX = HDR_BYTES + NUM_REGS;
  localparam int RXW    = $clog2(RX_MAX + 1);
  localparam int TXW    = $clog2(NUM_REGS + 2);
  localparam logic [RXW-1:0] RX_LIMIT = RXW'(RX_MAX);
  localparam logic [RXW-1:0] HDR_L    = RXW'(HDR_BYTES);
  localparam logic [TXW-1:0] TX_REGS  = TXW'(NUM_REGS);
  localparam logic [TXW-1:0] TX_LAST  = TXW'(NUM_REGS + 1);
  localparam logic [7:0]     COUNT_B  = 8'(NUM_REGS);

  xfer_state_e      state;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             byte_full;
  logic             rw;
  logic [RXW-1:0]   rx_cnt;
  logic [TXW-1:0]   tx_cnt;
  logic [7:0]       tx_byte;

  assign rd_idx = (tx_cnt == '0) ? '0 : IDX_W'(tx_cnt - TXW'(1));

  always_comb begin
    if (tx_cnt == '0)          tx_byte = COUNT_B;
    else if (tx_cnt <= TX_REGS) tx_byte = rd_data;
    else                        tx_byte = 8'hFF;
  end

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      sda_oe    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_full <= 1'b0;
      rw        <= 1'b0;
      rx_cnt    <= '0;
      tx_cnt    <= '0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else if (start_det) begin
      state     <= ST_ADDR;
      sda_oe    <= 1'b0;
      bit_cnt   <= '0;
      byte_full <= 1'b0;
      rx_cnt    <= '0;
      tx_cnt    <= '0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      sda_oe    <= 1'b0;
      byte_full <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_h};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_full <= 1'b1;
          end else if (scl_fall && byte_full) begin
            byte_full <= 1'b0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                rw     <= shreg[0];
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_IDLE;
              end
            end else if (rx_cnt < RX_LIMIT) begin
              sda_oe <= 1'b1;
              state  <= ST_WR_ACK;
              rx_cnt <= rx_cnt + RXW'(1);
              if (rx_cnt >= HDR_L) begin
                wr_en   <= 1'b1;
                wr_idx  <= IDX_W'(rx_cnt - HDR_L);
                wr_data <= shreg;
              end
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              shreg  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              tx_cnt <= tx_cnt + TXW'(1);
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              shreg   <= {shreg[6:0], 1'b1};
              sda_oe  <= ~shreg[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            state <= sda_h ? ST_IDLE : ST_RD_LOAD;
          end
        end
        ST_RD_LOAD: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            shreg   <= tx_byte;
            sda_oe  <= ~tx_byte[7];
            if (tx_cnt != TX_LAST) tx_cnt <= tx_cnt + TXW'(1);
            state   <= ST_RD;
          end
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave #(
  parameter logic [6:0]            DEV_ADDR  = 7'h69,
  parameter int                    NUM_REGS  = 6,
  parameter int                    HDR_BYTES = 2,
  parameter int                    SYNC_STG  = 2,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = 48'hFFFF_FFFF_FF00,
  parameter logic [NUM_REGS*8-1:0] RO_MASK   = 48'h000A_4000_8000,
  localparam int                   IDX_W     = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  input  logic [NUM_REGS*8-1:0] status_in,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  logic             sda_h;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_data;

  cfg_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_h     (sda_h),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfg_proto_fsm #(
    .DEV_ADDR  (DEV_ADDR),
    .NUM_REGS  (NUM_REGS),
    .HDR_BYTES (HDR_BYTES)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_h     (sda_h),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  cfg_reg_bank #(
    .NUM_REGS  (NUM_REGS),
    .RESET_VAL (RESET_VAL),
    .RO_MASK   (RO_MASK)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .status_in (status_in),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .cfg_o     (cfg_o)
  );

endmodule

// File: rtl/cfg_i2c_checker.sv
module cfg_i2c_checker #(
  parameter int                    NUM_REGS  = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = '1,
  parameter logic [NUM_REGS*8-1:0] RO_MASK   = '0,
  localparam int                   IDX_W     = $clog2(NUM_REGS + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sda_oe,
  input logic                  scl_fall,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [NUM_REGS*8-1:0] status_in,
  input logic [NUM_REGS*8-1:0] cfg_o
);

  AST_DEFAULTS_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (((cfg_o ^ RESET_VAL) & ~RO_MASK) == '0)); // R1

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < IDX_W'(NUM_REGS))); // R5

  AST_RO_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (rst)
    ((cfg_o & RO_MASK) == ($past(status_in) & RO_MASK))); // R8

  AST_OE_MOVES_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R10

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R10

endmodule

bind clkgen_cfg_slave cfg_i2c_checker #(
  .NUM_REGS  (NUM_REGS),
  .RESET_VAL (RESET_VAL),
  .RO_MASK   (RO_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .status_in (status_in),
  .cfg_o     (cfg_o)
);

// File: tb/clkgen_cfg_slave_bench.sv
`timescale 1ns/1ps
module clkgen_cfg_slave_bench;

  localparam int          NREG = 6;
  localparam int          Q    = 20;
  localparam logic [47:0] RV   = 48'hFFFF_FFFF_FF00;
  localparam logic [47:0] ROM  = 48'h000A_4000_8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        m_low = 1'b0;
  logic [47:0] status = 48'h0;
  logic        sda_oe;
  logic [47:0] cfg_o;
  wire         sda_bus = !(m_low || sda_oe);

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;

  clkgen_cfg_slave u_clkgen_cfg_slave (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl),
    .sda_in    (sda_bus),
    .sda_oe    (sda_oe),
    .status_in (status),
    .cfg_o     (cfg_o)
  );

  function automatic logic [47:0] expect_cfg();
    logic [47:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return (v & ~ROM) | (status & ROM);
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison of the outputs against the behavioural model
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      checks++;
      if (cfg_o !== expect_cfg()) begin
        errors++;
        $display("FAIL R3 model compare: actual=%h expected=%h", cfg_o, expect_cfg());
      end
    end
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq();
    scl = 1'b1;   wq();
    m_low = 1'b1; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq();
    scl = 1'b1;   wq();
    m_low = 1'b0; wq(); wq();
  endtask

  task automatic put_bit(input logic v);
    m_low = !v; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic v);
    m_low = 1'b0; wq();
    scl = 1'b1;   wq();
    v = sda_bus;  wq();
    scl = 1'b0;   wq();
  endtask

  // slot: register the requirements say this byte lands in, or -1
  task automatic send_byte(input logic [7:0] b, input int slot, output bit ack);
    logic a;
    if (slot >= 0) cmp_en = 1'b0;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    ack = !a;
    if (slot >= 0 && slot < NREG) model[slot] = b;
    cmp_en = 1'b1;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(v);
      b[i] = v;
    end
    put_bit(!give_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    logic [47:0] e;
    for (int i = 0; i < NREG; i++) model[i] = RV[i*8 +: 8];
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset defaults and released bus
    chk("R1 defaults", cfg_o, expect_cfg());
    chk("R1 sda released", {47'd0, sda_oe}, 48'd0);
    cmp_en = 1'b1;

    // R2 R3: full block write
    bus_start();
    send_byte(8'hD2, -1, ack); chk("R2 write address ack", {47'd0, ack}, 48'd1);
    send_byte(8'h3C, -1, ack); chk("R3 command ack", {47'd0, ack}, 48'd1);
    send_byte(8'h99, -1, ack); chk("R3 count ack", {47'd0, ack}, 48'd1);
    for (int i = 0; i < NREG; i++) begin
      send_byte(8'h11 * (i + 1), i, ack);
      chk("R3 data ack", {47'd0, ack}, 48'd1);
    end
    bus_stop();
    chk("R3 stored bytes", cfg_o, expect_cfg());

    // R6: block read
    bus_start();
    send_byte(8'hD3, -1, ack); chk("R2 read address ack", {47'd0, ack}, 48'd1);
    recv_byte(1'b1, rb); chk("R6 count byte", {40'd0, rb}, 48'd6);
    e = expect_cfg();
    for (int i = 0; i < NREG; i++) begin
      recv_byte(i != NREG - 1, rb);
      chk("R6 readback byte", {40'd0, rb}, {40'd0, e[i*8 +: 8]});
    end
    bus_stop();
    chk("R10 released after stop", {47'd0, sda_oe}, 48'd0);

    // R4: short write, two data bytes then STOP
    bus_start();
    send_byte(8'hD2, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'hA5, 0, ack);
    send_byte(8'h5A, 1, ack);
    bus_stop();
    chk("R4 partial write", cfg_o, expect_cfg());

    // R5: seven data bytes, the last one refused
    bus_start();
    send_byte(8'hD2, -1, ack);
    send_byte(8'h01, -1, ack);
    send_byte(8'h02, -1, ack);
    for (int i = 0; i < NREG; i++) send_byte(8'hF0 ^ 8'(i), i, ack);
    send_byte(8'h77, -1, ack);
    chk("R5 extra byte nack", {47'd0, ack}, 48'd0);
    bus_stop();
    chk("R5 nothing stored", cfg_o, expect_cfg());

    // R2: foreign address ignored
    bus_start();
    send_byte(8'hA0, -1, ack);
    chk("R2 foreign address nack", {47'd0, ack}, 48'd0);
    send_byte(8'h00, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'h00, -1, ack);
    chk("R2 following byte nack", {47'd0, ack}, 48'd0);
    bus_stop();
    chk("R2 registers unchanged", cfg_o, expect_cfg());

    // R8: read-only bits follow status, writes ignored
    cmp_en = 1'b0;
    status = 48'hFFFF_FFFF_FFFF;
    repeat (4) @(posedge clk);
    #1 cmp_en = 1'b1;
    chk("R8 status visible", cfg_o & ROM, ROM);
    bus_start();
    send_byte(8'hD2, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'h00, -1, ack);
    for (int i = 0; i < NREG; i++) send_byte(8'h00, i, ack);
    bus_stop();
    chk("R8 write ignored", cfg_o, ROM);
    bus_start();
    send_byte(8'hD3, -1, ack);
    recv_byte(1'b1, rb);
    recv_byte(1'b1, rb);
    recv_byte(1'b0, rb);
    chk("R8 readback live bit", {40'd0, rb}, 48'h80);
    // R7: after the NACK the slave must not drive
    recv_byte(1'b0, rb);
    chk("R7 released after nack", {40'd0, rb}, 48'hFF);
    bus_stop();
    cmp_en = 1'b0;
    status = 48'h0;
    repeat (4) @(posedge clk);
    #1 cmp_en = 1'b1;
    chk("R8 status cleared", cfg_o & ROM, 48'd0);

    // R9: repeated START mid-byte restarts at byte 0
    bus_start();
    send_byte(8'hD2, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'h3E, 0, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte(8'hD2, -1, ack); chk("R9 address after restart", {47'd0, ack}, 48'd1);
    send_byte(8'h00, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'hC3, 0, ack);
    bus_start();
    send_byte(8'hD3, -1, ack); chk("R9 read after restart", {47'd0, ack}, 48'd1);
    recv_byte(1'b1, rb); chk("R9 count after restart", {40'd0, rb}, 48'd6);
    recv_byte(1'b0, rb); chk("R9 byte0 restarted", {40'd0, rb}, 48'hC3);
    bus_stop();
    chk("R9 final state", cfg_o, expect_cfg());

    cmp_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule